// File: doc/BRIEF.md
# LCD Row-Scan Timing Generator

This block produces the scan timing for the row (common) side of a dot-matrix LCD. It runs from an oscillator clock. From that clock it makes a line clock at half the oscillator rate, plus a frame marker that is high for one line period at the start of every frame. A frame is either 120 or 240 lines long, chosen by a frame-length input. The block also produces a polarity (alternating) signal that flips at every frame start. It drives a display-enable control that stays inactive for four frames after reset and whenever an external blanking request is asserted.

A master/slave select decides where the timing comes from. In master mode the internal generator drives the four pin outputs and raises their output enables, so a top level can model bidirectional pads. In slave mode the generator freezes its whole state and drops the enables. The scan outputs that feed the local row shift register then pass the four external input pins straight through. In master mode the scan outputs carry the generated signals.

Top module: `lcd_com_timing_gen`

## Requirements
- R1: In master mode `lclk_o` inverts on every rising `osc_clk` edge, giving a line clock of two oscillator cycles with 50% duty. The first edge after reset release drives it high.
- R2: `fmark_o` rises once every 240 line-clock rising edges when `long_frame` is 1, and once every 120 when it is 0. The first rise after reset comes on the 120th or 240th line-clock rise.
- R3: `fmark_o` rises on the same oscillator edge as a rising edge of `lclk_o` and stays high for exactly two oscillator cycles, one full line period. It is therefore stable across the falling line-clock edge.
- R4: `rst_n` low resets asynchronously. `lclk_o`, `fmark_o`, `alt_o` and `dispctl_o` go low at once and the line and frame counters clear.
- R5: After reset release `dispctl_o` stays low until the oscillator edge on which the fourth frame marker rises. It goes high on that edge if `blank_req_n` is high, and the four-frame count saturates instead of wrapping.
- R6: In master mode, `blank_req_n` low at an oscillator edge makes `dispctl_o` low after that edge. Once blanking has ended, `dispctl_o` returns high on the first edge with `blank_req_n` high.
- R7: `alt_o` starts low after reset and inverts on every edge at which the frame marker rises.
- R8: With `master_sel` 1, all four output enables are 1 and each scan output equals the matching generated output. With `master_sel` 0, all enables are 0, each scan output equals its external input, and every generated output and internal counter holds its value.
- R9: If the line count is already at or beyond the last line of the newly selected frame length, the next line-clock rise wraps the count to line 0 and raises the frame marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_sel | input | 1 | 1 = generate timing, 0 = follow external pins |
| long_frame | input | 1 | 1 = 240-line frame, 0 = 120-line frame |
| blank_req_n | input | 1 | Blanking request, active low (master only) |
| lclk_in | input | 1 | External line clock (slave) |
| fmark_in | input | 1 | External frame marker (slave) |
| alt_in | input | 1 | External polarity signal (slave) |
| dispctl_in | input | 1 | External display-enable control (slave) |
| lclk_o | output | 1 | Generated line clock |
| fmark_o | output | 1 | Generated frame marker |
| alt_o | output | 1 | Generated polarity signal |
| dispctl_o | output | 1 | Generated display-enable control |
| lclk_oe | output | 1 | Output enable for the line clock pin |
| fmark_oe | output | 1 | Output enable for the frame marker pin |
| alt_oe | output | 1 | Output enable for the polarity pin |
| dispctl_oe | output | 1 | Output enable for the display-enable pin |
| scan_lclk | output | 1 | Line clock used by the local row scan |
| scan_fmark | output | 1 | Frame marker used by the local row scan |
| scan_alt | output | 1 | Polarity used by the local row scan |
| scan_dispctl | output | 1 | Display-enable used by the local row scan |

## Verification
A corrupted line counter shows up at `fmark_o` within one frame: the marker arrives early, late or twice, and `alt_o` then drifts out of phase for the rest of the run. A wrong blanking count shows in how many markers have passed before `dispctl_o` first rises, so the error is visible within the first four or five frames after reset. A generator that keeps running in slave mode is caught on the first slave cycle, because the generated outputs move while they should hold. After the return to master mode, the marker phase is then off by the number of slave cycles.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

    typedef struct packed {
        logic lclk;
        logic fmark;
        logic alt;
        logic dispctl;
    } tg_pins_t;

    localparam int unsigned TG_PIN_COUNT = $bits(tg_pins_t);

endpackage

// File: rtl/lcd_tg_line_gen.sv
module lcd_tg_line_gen #(
    parameter int unsigned LINES_LONG  = 240,
    parameter int unsigned LINES_SHORT = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic long_frame,
    output logic lclk,
    output logic fmark,
    output logic mark_start
);
    localparam int unsigned CNT_W = $clog2(LINES_LONG);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LINES_LONG - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(LINES_SHORT - 1);

    typedef struct packed {
        logic             lclk;
        logic [CNT_W-1:0] line;
        logic             fmark;
    } line_st_t;

    line_st_t st_q, st_d;
    logic [CNT_W-1:0] last_line;
    logic             start_d;

    assign last_line = long_frame ? LAST_LONG : LAST_SHORT;

    always_comb begin
        st_d    = st_q;
        start_d = 1'b0;
        if (run) begin
            st_d.lclk = ~st_q.lclk;
            if (!st_q.lclk) begin
                // rising line clock: advance the line, wrap past the end
                if (st_q.line >= last_line) begin
                    st_d.line = '0;
                end else begin
                    st_d.line = st_q.line + 1'b1;
                end
                st_d.fmark = (st_d.line == '0);
                start_d    = st_d.fmark;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lclk       = st_q.lclk;
    assign fmark      = st_q.fmark;
    assign mark_start = start_d;

endmodule

// File: rtl/lcd_tg_blank_ctl.sv
module lcd_tg_blank_ctl #(
    parameter int unsigned BLANK_FRAMES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic mark_start,
    input  logic blank_req_n,
    output logic dispctl,
    output logic alt
);
    localparam int unsigned BLK_W = $clog2(BLANK_FRAMES + 1);
    localparam logic [BLK_W-1:0] BLK_DONE = BLK_W'(BLANK_FRAMES);

    typedef struct packed {
        logic [BLK_W-1:0] frames;
        logic             disp;
        logic             alt;
    } blank_st_t;

    blank_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (run) begin
            if (mark_start && (st_q.frames != BLK_DONE)) begin
                st_d.frames = st_q.frames + 1'b1;
            end
            st_d.alt  = st_q.alt ^ mark_start;
            st_d.disp = (st_d.frames == BLK_DONE) && blank_req_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dispctl = st_q.disp;
    assign alt     = st_q.alt;

endmodule

// File: rtl/lcd_tg_pin_mux.sv
module lcd_tg_pin_mux
    import lcd_tg_pkg::*;
(
    input  logic     master,
    input  tg_pins_t gen_pins,
    input  tg_pins_t ext_pins,
    output tg_pins_t oe_pins,
    output tg_pins_t scan_pins
);
    logic [TG_PIN_COUNT-1:0] gen_v, ext_v, oe_v, scan_v;

    assign gen_v = gen_pins;
    assign ext_v = ext_pins;

    for (genvar i = 0; i < TG_PIN_COUNT; i++) begin : g_pin
        assign oe_v[i]   = master;
        assign scan_v[i] = master ? gen_v[i] : ext_v[i];
    end

    assign oe_pins   = oe_v;
    assign scan_pins = scan_v;

endmodule

// File: rtl/lcd_com_timing_gen.sv
module lcd_com_timing_gen
    import lcd_tg_pkg::*;
#(
    parameter int unsigned LINES_LONG   = 240,
    parameter int unsigned LINES_SHORT  = 120,
    parameter int unsigned BLANK_FRAMES = 4
) (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic master_sel,
    input  logic long_frame,
    input  logic blank_req_n,
    input  logic lclk_in,
    input  logic fmark_in,
    input  logic alt_in,
    input  logic dispctl_in,
    output logic lclk_o,
    output logic fmark_o,
    output logic alt_o,
    output logic dispctl_o,
    output logic lclk_oe,
    output logic fmark_oe,
    output logic alt_oe,
    output logic dispctl_oe,
    output logic scan_lclk,
    output logic scan_fmark,
    output logic scan_alt,
    output logic scan_dispctl
);
    logic     mark_start;
    tg_pins_t gen_pins, ext_pins, oe_pins, scan_pins;

    lcd_tg_line_gen #(
        .LINES_LONG (LINES_LONG),
        .LINES_SHORT(LINES_SHORT)
    ) line_i (
        .clk       (osc_clk),
        .rst_n     (rst_n),
        .run       (master_sel),
        .long_frame(long_frame),
        .lclk      (gen_pins.lclk),
        .fmark     (gen_pins.fmark),
        .mark_start(mark_start)
    );

    lcd_tg_blank_ctl #(
        .BLANK_FRAMES(BLANK_FRAMES)
    ) blank_i (
        .clk        (osc_clk),
        .rst_n      (rst_n),
        .run        (master_sel),
        .mark_start (mark_start),
        .blank_req_n(blank_req_n),
        .dispctl    (gen_pins.dispctl),
        .alt        (gen_pins.alt)
    );

    assign ext_pins.lclk    = lclk_in;
    assign ext_pins.fmark   = fmark_in;
    assign ext_pins.alt     = alt_in;
    assign ext_pins.dispctl = dispctl_in;

    lcd_tg_pin_mux mux_i (
        .master   (master_sel),
        .gen_pins (gen_pins),
        .ext_pins (ext_pins),
        .oe_pins  (oe_pins),
        .scan_pins(scan_pins)
    );

    assign lclk_o       = gen_pins.lclk;
    assign fmark_o      = gen_pins.fmark;
    assign alt_o        = gen_pins.alt;
    assign dispctl_o    = gen_pins.dispctl;
    assign lclk_oe      = oe_pins.lclk;
    assign fmark_oe     = oe_pins.fmark;
    assign alt_oe       = oe_pins.alt;
    assign dispctl_oe   = oe_pins.dispctl;
    assign scan_lclk    = scan_pins.lclk;
    assign scan_fmark   = scan_pins.fmark;
    assign scan_alt     = scan_pins.alt;
    assign scan_dispctl = scan_pins.dispctl;

endmodule

// File: rtl/lcd_com_timing_chk.sv
module lcd_com_timing_chk #(
    parameter int unsigned BLANK_FRAMES = 4
) (
    input logic osc_clk,
    input logic rst_n,
    input logic master_sel,
    input logic blank_req_n,
    input logic lclk_in,
    input logic lclk_o,
    input logic fmark_o,
    input logic alt_o,
    input logic dispctl_o,
    input logic lclk_oe,
    input logic scan_lclk
);
    localparam int unsigned SEEN_W = $clog2(BLANK_FRAMES + 1);

    logic [SEEN_W-1:0] seen_q;
    logic              fmark_prev_q;
    logic              mark_now;
    logic [SEEN_W:0]   seen_now;

    assign mark_now = fmark_o && !fmark_prev_q;
    assign seen_now = {1'b0, seen_q} + {{SEEN_W{1'b0}}, mark_now};

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q       <= '0;
            fmark_prev_q <= 1'b0;
        end else begin
            fmark_prev_q <= fmark_o;
            if (mark_now && (seen_q != SEEN_W'(BLANK_FRAMES))) begin
                seen_q <= seen_q + 1'b1;
            end
        end
    end

    p_lclk_toggle_r1: assert property (@(posedge osc_clk) disable iff (!rst_n)
        master_sel |=> (lclk_o != $past(lclk_o)));

    p_mark_on_rise_r3: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(fmark_o) |-> $rose(lclk_o));

    p_mark_width_r3: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(fmark_o) |=> fmark_o);

    p_alt_on_mark_r7: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (alt_o != $past(alt_o)) |-> $rose(fmark_o));

    p_blank_frames_r5: assert property (@(posedge osc_clk) disable iff (!rst_n)
        dispctl_o |-> (seen_now >= (SEEN_W + 1)'(BLANK_FRAMES)));

    p_req_dark_r6: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (master_sel && !blank_req_n) |=> !dispctl_o);

    p_slave_hold_r8: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !master_sel |=> ($stable(lclk_o) && $stable(fmark_o) && $stable(dispctl_o)));

    p_slave_pass_r8: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !master_sel |-> (!lclk_oe && (scan_lclk == lclk_in)));

endmodule

bind lcd_com_timing_gen lcd_com_timing_chk #(
    .BLANK_FRAMES(BLANK_FRAMES)
) chk_i (
    .osc_clk    (osc_clk),
    .rst_n      (rst_n),
    .master_sel (master_sel),
    .blank_req_n(blank_req_n),
    .lclk_in    (lclk_in),
    .lclk_o     (lclk_o),
    .fmark_o    (fmark_o),
    .alt_o      (alt_o),
    .dispctl_o  (dispctl_o),
    .lclk_oe    (lclk_oe),
    .scan_lclk  (scan_lclk)
);

// File: tb/lcd_com_timing_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_com_timing_gen_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, master_sel, long_frame, blank_req_n;
    logic lclk_in, fmark_in, alt_in, dispctl_in;
    logic lclk_o, fmark_o, alt_o, dispctl_o;
    logic lclk_oe, fmark_oe, alt_oe, dispctl_oe;
    logic scan_lclk, scan_fmark, scan_alt, scan_dispctl;

    lcd_com_timing_gen dut_i (
        .osc_clk(clk), .rst_n(rst_n), .master_sel(master_sel),
        .long_frame(long_frame), .blank_req_n(blank_req_n),
        .lclk_in(lclk_in), .fmark_in(fmark_in), .alt_in(alt_in), .dispctl_in(dispctl_in),
        .lclk_o(lclk_o), .fmark_o(fmark_o), .alt_o(alt_o), .dispctl_o(dispctl_o),
        .lclk_oe(lclk_oe), .fmark_oe(fmark_oe), .alt_oe(alt_oe), .dispctl_oe(dispctl_oe),
        .scan_lclk(scan_lclk), .scan_fmark(scan_fmark), .scan_alt(scan_alt),
        .scan_dispctl(scan_dispctl)
    );

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    logic exp_disp = 1'b0;

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int frame_len(input logic lf);
        return lf ? 240 : 120;
    endfunction

    function automatic logic exp_mark(input int rises, input int n);
        return (rises >= n) && ((rises % n) == 0);
    endfunction

    task automatic check_pins();
        chk("R8 lclk_oe", lclk_oe, master_sel);
        chk("R8 fmark_oe", fmark_oe, master_sel);
        chk("R8 alt_oe", alt_oe, master_sel);
        chk("R8 dispctl_oe", dispctl_oe, master_sel);
        chk("R8 scan_lclk", scan_lclk, master_sel ? lclk_o : lclk_in);
        chk("R8 scan_fmark", scan_fmark, master_sel ? fmark_o : fmark_in);
        chk("R8 scan_alt", scan_alt, master_sel ? alt_o : alt_in);
        chk("R8 scan_dispctl", scan_dispctl, master_sel ? dispctl_o : dispctl_in);
    endtask

    task automatic do_reset(input logic lf);
        @(posedge clk);
        #1;
        rst_n       = 1'b0;
        master_sel  = 1'b1;
        long_frame  = lf;
        blank_req_n = 1'b1;
        #0.5;
        // R4: asynchronous clear, before any clock edge
        chk("R4 lclk", lclk_o, 1'b0);
        chk("R4 fmark", fmark_o, 1'b0);
        chk("R4 alt", alt_o, 1'b0);
        chk("R4 dispctl", dispctl_o, 1'b0);
        check_pins();
        repeat (3) @(negedge clk);
        rst_n    = 1'b1;
        edges    = 0;
        exp_disp = 1'b0;
    endtask

    // run n cycles; slave selects master_sel=0, req_rate = percent chance to flip request
    task automatic run_cycles(input int n, input bit slave, input int req_rate);
        master_sel = !slave;
        for (int c = 0; c < n; c++) begin
            logic req_at_edge;
            logic was_master;
            int   rises, nlen;
            @(posedge clk);
            req_at_edge = blank_req_n;
            was_master  = master_sel;
            if (was_master) edges++;
            #1;
            nlen  = frame_len(long_frame);
            rises = (edges + 1) / 2;
            if (was_master) exp_disp = ((rises / nlen) >= 4) && req_at_edge;
            chk("R1 lclk", lclk_o, logic'(edges % 2));
            chk("R2/R3 fmark", fmark_o, exp_mark(rises, nlen));
            chk("R7 alt", alt_o, logic'((rises / nlen) % 2));
            chk(req_at_edge ? "R5 dispctl" : "R6 dispctl", dispctl_o, exp_disp);
            if ($urandom_range(0, 99) < req_rate) blank_req_n = ~blank_req_n;
            if (slave) begin
                lclk_in    = 1'($urandom);
                fmark_in   = 1'($urandom);
                alt_in     = 1'($urandom);
                dispctl_in = 1'($urandom);
            end
            #0.5;
            check_pins();
        end
        blank_req_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; master_sel = 1'b1; long_frame = 1'b0; blank_req_n = 1'b1;
        lclk_in = 1'b0; fmark_in = 1'b0; alt_in = 1'b0; dispctl_in = 1'b0;

        // short frames: blanking ends at fourth marker, then slave pause, then random requests
        do_reset(1'b0);
        run_cycles(2000, 1'b0, 0);
        run_cycles(150, 1'b1, 0);
        run_cycles(2000, 1'b0, 4);
        run_cycles(37, 1'b1, 5);
        run_cycles(1500, 1'b0, 2);

        // long frames
        do_reset(1'b1);
        run_cycles(1000, 1'b0, 3);
        run_cycles(61, 1'b1, 0);
        run_cycles(4000, 1'b0, 0);
        run_cycles(1200, 1'b0, 6);

        // R9: shorten the frame while the line count is beyond the short end
        do_reset(1'b1);
        run_cycles(300, 1'b0, 0);
        long_frame = 1'b0;
        for (int c = 1; c <= 241; c++) begin
            @(posedge clk);
            #1;
            if (c == 1)   chk("R9 wrap marker", fmark_o, 1'b1);
            if (c == 3)   chk("R9 marker ends", fmark_o, 1'b0);
            if (c == 239) chk("R9 before next", fmark_o, 1'b0);
            if (c == 241) chk("R9 next marker", fmark_o, 1'b1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule